// File: doc/BRIEF.md
# Sequence-ID Matched Producer/Consumer Channel

This block carries values from a producer that may finish its work out of order to a consumer that reads them strictly in program order. Each value arrives tagged with the program-order sequence number it belongs to. The consumer keeps its own counter of the next sequence number it needs, and it is served only the entry that carries exactly that number.

Entries that arrive in sequence fill an in-order FIFO. Entries that arrive ahead of their turn are parked in a small associative store, which is searched by ID. An entry can also be a pointer packet. Its payload is then an index into a small temporary store that the consumer writes with values it has recently computed. When the consumer takes a pointer packet, it gets the value from that store in place of a payload from the producer.

The FIFO takes an entry only if its ID equals the FIFO's expected ID. That expected ID moves forward when the FIFO accepts an entry, when the associative store already holds that ID, or when the consumer takes that ID. The window of IDs in flight must stay smaller than the ID range.

Top module: `seq_match_channel`

## Requirements
- R1: After reset, `cns_ready` is low, `cns_id` is 0, and `prd_ready` is high for an entry with ID 0.
- R2: Entries produced in ID order are delivered to the consumer in that order, with their payloads unchanged and `cns_from_tmp` low.
- R3: Entries produced in any order are delivered to the consumer in ascending ID order, each with its own payload.
- R4: While no stored entry carries the current `cns_id`, `cns_ready` stays low and `cns_id` holds its value.
- R5: A consume happens when `cns_req` and `cns_ready` are both high at a clock edge. Each consume raises `cns_id` by exactly one (modulo 2^ID_W) and frees the matching entry, so that entry is never delivered a second time.
- R6: When the associative store is full, an entry whose ID differs from the FIFO's expected ID is refused (`prd_ready` low). An entry carrying the expected ID is still accepted.
- R7: When the FIFO holds FIFO_DEPTH entries, an entry carrying the expected ID is refused (`prd_ready` low).
- R8: An entry produced with `prd_is_ptr` = 1 is delivered as the temporary-store word at index `prd_payload[TIDX_W-1:0]`, and `cns_from_tmp` is high while it is offered.
- R9: A temporary-store write to the same index in the same cycle as a pointer consume does not change the value delivered by that consume. The written value is delivered by later pointer consumes.
- R10: An entry accepted at a clock edge cannot satisfy the consumer before that edge. `cns_ready` reflects it only from the following cycle.
- R11: A given ID is never present at the FIFO head and in the associative store at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prd_valid | input | 1 | Producer offers an entry |
| prd_ready | output | 1 | Entry is accepted at this edge if valid |
| prd_id | input | ID_W | Program-order sequence ID of the entry |
| prd_is_ptr | input | 1 | Entry is a pointer into the temporary store |
| prd_payload | input | DATA_W | Data, or the temporary-store index in its low bits |
| cns_req | input | 1 | Consumer wants the value for `cns_id` |
| cns_ready | output | 1 | The value for `cns_id` is available |
| cns_id | output | ID_W | Sequence ID the consumer expects next |
| cns_data | output | DATA_W | Delivered value |
| cns_from_tmp | output | 1 | Delivered value came from the temporary store |
| tmp_we | input | 1 | Consumer writes the temporary store |
| tmp_idx | input | TIDX_W | Temporary-store write index |
| tmp_wdata | input | DATA_W | Temporary-store write data |

## Verification
The bench builds the channel with a four-entry FIFO, a four-entry associative store, an eight-word temporary store, 6-bit IDs and 16-bit data. With those sizes, a few entries are enough to fill either structure, so refusals caused by a full FIFO and by a full associative store can be provoked directly. The small sizes also let reordered arrivals exercise the skipping of the expected ID over entries already parked. The same-cycle hazard between a temporary-store write and a pointer consume is provoked at one fixed index.

// File: rtl/seqch_pkg.sv
// Shared definitions for the sequence-matched channel.
// Assumes: nothing beyond IEEE 1800-2017.
package seqch_pkg;

    // Which storage structure supplies the current consume
    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_FIFO  = 2'd1,
        SRC_ASSOC = 2'd2
    } src_e;

    // Pointer index width for a given temporary-store depth
    function automatic int idx_width(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/seqch_fifo.sv
// Circular in-order queue of channel entries.
// Assumes: DEPTH >= 2; the caller never pushes when full or pops when empty.
module seqch_fifo #(
    parameter int W     = 41,
    parameter int DEPTH = 512
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CMAX = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    assign empty = (count == '0);
    assign full  = (count == CMAX);
    assign head  = mem[rd_ptr];

    // Storage write; payload cells need no reset
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R7
    fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop));
    // R5
    fifo_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/seqch_assoc.sv
// Associative store for entries that arrive ahead of their turn.
// Looked up by ID on two ports: one for the consumer, one for the
// expected-ID probe. An insert goes into the lowest free slot.
// Assumes: IDs held in the store are unique.
module seqch_assoc #(
    parameter int ID_W  = 10,
    parameter int PW    = 33,
    parameter int DEPTH = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ins,
    input  logic [ID_W-1:0] ins_id,
    input  logic [PW-1:0]   ins_pay,
    input  logic [ID_W-1:0] find_id,
    output logic            find_hit,
    output logic [PW-1:0]   find_pay,
    input  logic            rel,
    input  logic [ID_W-1:0] probe_id,
    output logic            probe_hit,
    output logic            full
);
    localparam int SW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0] vld;
    logic [ID_W-1:0]  ids  [DEPTH];
    logic [PW-1:0]    pays [DEPTH];
    logic [DEPTH-1:0] find_m, probe_m;
    logic [SW-1:0]    free_slot;

    // Per-slot comparators
    for (genvar s = 0; s < DEPTH; s++) begin : g_cmp
        assign find_m[s]  = vld[s] && (ids[s] == find_id);
        assign probe_m[s] = vld[s] && (ids[s] == probe_id);
    end

    assign find_hit  = |find_m;
    assign probe_hit = |probe_m;
    assign full      = &vld;

    // One-hot payload selection for the consumer port
    always_comb begin
        find_pay = '0;
        for (int s = 0; s < DEPTH; s++)
            if (find_m[s]) find_pay = find_pay | pays[s];
    end

    // Lowest free slot for inserts
    always_comb begin
        free_slot = '0;
        for (int s = DEPTH - 1; s >= 0; s--)
            if (!vld[s]) free_slot = SW'(s);
    end

    // Slot contents; written only on insert
    always_ff @(posedge clk) begin
        if (ins) begin
            ids[free_slot]  <= ins_id;
            pays[free_slot] <= ins_pay;
        end
    end

    // Slot occupancy: set on insert, cleared on consume
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else begin
            for (int s = 0; s < DEPTH; s++) begin
                if (rel && find_m[s])                  vld[s] <= 1'b0;
                else if (ins && free_slot == SW'(s))   vld[s] <= 1'b1;
            end
        end
    end

    // R6
    assoc_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins |-> !full);
    // R11
    assoc_unique_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(find_m));
    // R5
    assoc_release_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel |-> find_hit);
endmodule

// File: rtl/seqch_tmpstore.sv
// Consumer-local temporary store for recently computed values.
// The read is combinational and a write lands at the edge, so a read in
// the cycle of a write returns the old word.
// Assumes: the index is always in range.
module seqch_tmpstore #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    parameter int IW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IW-1:0]     rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] words [DEPTH];

    assign rd_data = words[rd_idx];

    // Word storage with clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) words[w] <= '0;
        end else if (wr_en) begin
            words[wr_idx] <= wr_data;
        end
    end
endmodule

// File: rtl/seq_match_channel.sv
// Sequence-ID matched producer/consumer channel.
// Routes each produced entry to the in-order FIFO when its ID equals the
// FIFO's expected ID, otherwise to the associative store. It serves the
// consumer only the entry whose ID equals the consume counter, and turns
// pointer entries into reads of the temporary store.
// Assumes: produced IDs are unique within the in-flight window, and that
// window is smaller than 2^ID_W.
module seq_match_channel
    import seqch_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ID_W       = 10,
    parameter int FIFO_DEPTH = 512,
    parameter int CAM_DEPTH  = 32,
    parameter int TMP_DEPTH  = 16,
    localparam int TIDX_W    = idx_width(TMP_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prd_valid,
    output logic              prd_ready,
    input  logic [ID_W-1:0]   prd_id,
    input  logic              prd_is_ptr,
    input  logic [DATA_W-1:0] prd_payload,
    input  logic              cns_req,
    output logic              cns_ready,
    output logic [ID_W-1:0]   cns_id,
    output logic [DATA_W-1:0] cns_data,
    output logic              cns_from_tmp,
    input  logic              tmp_we,
    input  logic [TIDX_W-1:0] tmp_idx,
    input  logic [DATA_W-1:0] tmp_wdata
);
    localparam int PW = DATA_W + 1;
    localparam int EW = ID_W + PW;

    logic [ID_W-1:0]   exp_id;
    logic              to_fifo, push_fifo, ins_cam;
    logic [EW-1:0]     fifo_head;
    logic              fifo_empty, fifo_full;
    logic              head_hit, cam_hit, probe_hit, cam_full;
    logic [PW-1:0]     cam_pay, sel_pay;
    logic              fire, pop_fifo, rel_cam;
    logic [DATA_W-1:0] tmp_rd;
    src_e              src;

    // Producer routing and back-pressure
    always_comb begin
        to_fifo   = (prd_id == exp_id);
        prd_ready = to_fifo ? !fifo_full : !cam_full;
        push_fifo = prd_valid && to_fifo && !fifo_full;
        ins_cam   = prd_valid && !to_fifo && !cam_full;
    end

    seqch_fifo #(.W(EW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_fifo),
        .push_data ({prd_id, prd_is_ptr, prd_payload}),
        .pop       (pop_fifo),
        .head      (fifo_head),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    seqch_assoc #(.ID_W(ID_W), .PW(PW), .DEPTH(CAM_DEPTH)) u_assoc (
        .clk       (clk),
        .rst_n     (rst_n),
        .ins       (ins_cam),
        .ins_id    (prd_id),
        .ins_pay   ({prd_is_ptr, prd_payload}),
        .find_id   (cns_id),
        .find_hit  (cam_hit),
        .find_pay  (cam_pay),
        .rel       (rel_cam),
        .probe_id  (exp_id),
        .probe_hit (probe_hit),
        .full      (cam_full)
    );

    seqch_tmpstore #(.DATA_W(DATA_W), .DEPTH(TMP_DEPTH), .IW(TIDX_W)) u_tmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tmp_we),
        .wr_idx  (tmp_idx),
        .wr_data (tmp_wdata),
        .rd_idx  (sel_pay[TIDX_W-1:0]),
        .rd_data (tmp_rd)
    );

    // Match the consume ID, FIFO head first
    always_comb begin
        head_hit = !fifo_empty && (fifo_head[EW-1 -: ID_W] == cns_id);
        if (head_hit)     src = SRC_FIFO;
        else if (cam_hit) src = SRC_ASSOC;
        else              src = SRC_NONE;
        sel_pay   = (src == SRC_FIFO) ? fifo_head[PW-1:0] : cam_pay;
        cns_ready = (src != SRC_NONE);
        fire      = cns_req && cns_ready;
        pop_fifo  = fire && (src == SRC_FIFO);
        rel_cam   = fire && (src == SRC_ASSOC);
    end

    // Delivered value: payload or temporary-store word
    always_comb begin
        cns_from_tmp = cns_ready && sel_pay[PW-1];
        cns_data     = cns_from_tmp ? tmp_rd : sel_pay[DATA_W-1:0];
    end

    // Consume counter: one step per consume
    always_ff @(posedge clk) begin
        if (!rst_n)    cns_id <= '0;
        else if (fire) cns_id <= cns_id + 1'b1;
    end

    // FIFO expected ID: skips IDs pushed, parked, or already consumed
    always_ff @(posedge clk) begin
        if (!rst_n)
            exp_id <= '0;
        else if (push_fifo || probe_hit || (fire && cns_id == exp_id))
            exp_id <= exp_id + 1'b1;
    end

    // R11
    single_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(head_hit && cam_hit));
    // R5
    id_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cns_req && cns_ready) |=> (cns_id == $past(cns_id) + 1'b1));
    // R4
    id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cns_req && cns_ready) |=> $stable(cns_id));
    // R6
    refuse_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prd_valid && prd_id != exp_id && cam_full) |-> !prd_ready);
endmodule

// File: tb/seq_match_channel_tb.sv
// Directed bench for seq_match_channel: one task per scenario.
module seq_match_channel_tb;
    localparam int DW = 16;
    localparam int IW = 6;
    localparam int TW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prd_valid = 1'b0, prd_is_ptr = 1'b0;
    logic          prd_ready;
    logic [IW-1:0] prd_id = '0;
    logic [DW-1:0] prd_payload = '0;
    logic          cns_req = 1'b0;
    logic          cns_ready, cns_from_tmp;
    logic [IW-1:0] cns_id;
    logic [DW-1:0] cns_data;
    logic          tmp_we = 1'b0;
    logic [TW-1:0] tmp_idx = '0;
    logic [DW-1:0] tmp_wdata = '0;

    int n_chk = 0, n_fail = 0;
    int next_cons = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    seq_match_channel #(
        .DATA_W(DW), .ID_W(IW), .FIFO_DEPTH(4), .CAM_DEPTH(4), .TMP_DEPTH(8)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .prd_valid(prd_valid), .prd_ready(prd_ready), .prd_id(prd_id),
        .prd_is_ptr(prd_is_ptr), .prd_payload(prd_payload),
        .cns_req(cns_req), .cns_ready(cns_ready), .cns_id(cns_id),
        .cns_data(cns_data), .cns_from_tmp(cns_from_tmp),
        .tmp_we(tmp_we), .tmp_idx(tmp_idx), .tmp_wdata(tmp_wdata)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic produce(input int id, input bit ptr, input int pay, input bit accept, input string req);
        @(negedge clk);
        prd_valid = 1'b1; prd_id = IW'(id); prd_is_ptr = ptr; prd_payload = DW'(pay);
        #1 check(prd_ready == accept, req, prd_ready, accept);
        @(posedge clk);
        #1 prd_valid = 1'b0;
    endtask

    task automatic consume(input int exp_data, input bit exp_tmp, input string req);
        @(negedge clk);
        cns_req = 1'b1;
        #1;
        check(cns_ready == 1'b1, req, cns_ready, 1);
        check(cns_id == IW'(next_cons), req, cns_id, next_cons);
        check(cns_data == DW'(exp_data), req, cns_data, exp_data);
        check(cns_from_tmp == exp_tmp, req, cns_from_tmp, exp_tmp);
        @(posedge clk);
        #1 cns_req = 1'b0;
        next_cons++;
    endtask

    task automatic expect_stall(input string req);
        @(negedge clk);
        #1;
        check(cns_ready == 1'b0, req, cns_ready, 0);
        check(cns_id == IW'(next_cons), req, cns_id, next_cons);
    endtask

    task automatic tmp_write(input int idx, input int val);
        @(negedge clk);
        tmp_we = 1'b1; tmp_idx = TW'(idx); tmp_wdata = DW'(val);
        @(posedge clk);
        #1 tmp_we = 1'b0;
    endtask

    // R1: state after reset
    task automatic t_reset;
        @(negedge clk);
        prd_id = '0;
        #1;
        check(cns_ready == 1'b0, "R1", cns_ready, 0);
        check(cns_id == '0, "R1", cns_id, 0);
        check(prd_ready == 1'b1, "R1", prd_ready, 1);
    endtask

    // R2 and R7: in-order fill to full, then drain
    task automatic t_inorder;
        for (int i = 0; i < 4; i++) produce(i, 1'b0, 16'h100 + i, 1'b1, "R2");
        produce(4, 1'b0, 16'h104, 1'b0, "R7");
        for (int i = 0; i < 4; i++) consume(16'h100 + i, 1'b0, "R2");
        expect_stall("R5");
    endtask

    // R3 and R4: reordered arrival 6,5,4,7
    task automatic t_reorder;
        produce(6, 1'b0, 16'h206, 1'b1, "R3");
        expect_stall("R4");
        produce(5, 1'b0, 16'h205, 1'b1, "R3");
        expect_stall("R4");
        produce(4, 1'b0, 16'h204, 1'b1, "R3");
        produce(7, 1'b0, 16'h207, 1'b1, "R3");
        for (int i = 4; i < 8; i++) consume(16'h200 + i, 1'b0, "R3");
        expect_stall("R4");
    endtask

    // R6: associative store full refuses early IDs, accepts the expected one
    task automatic t_assoc_full;
        for (int i = 9; i < 13; i++) produce(i, 1'b0, 16'h300 + i, 1'b1, "R6");
        produce(13, 1'b0, 16'h30d, 1'b0, "R6");
        produce(8, 1'b0, 16'h308, 1'b1, "R6");
        for (int i = 8; i < 13; i++) consume(16'h300 + i, 1'b0, "R6");
    endtask

    // R10: no same-cycle bypass from produce to consume
    task automatic t_latency;
        @(negedge clk);
        prd_valid = 1'b1; prd_id = IW'(13); prd_is_ptr = 1'b0; prd_payload = 16'h40d;
        cns_req = 1'b1;
        #1 check(cns_ready == 1'b0, "R10", cns_ready, 0);
        @(posedge clk);
        #1 begin prd_valid = 1'b0; cns_req = 1'b0; end
        consume(16'h40d, 1'b0, "R10");
    endtask

    // R8: pointer entry reads the temporary store
    task automatic t_pointer;
        tmp_write(3, 16'hBEEF);
        produce(14, 1'b1, 3, 1'b1, "R8");
        consume(16'hBEEF, 1'b1, "R8");
    endtask

    // R9: write and pointer read of the same index in one cycle
    task automatic t_hazard;
        tmp_write(5, 16'h1111);
        produce(15, 1'b1, 5, 1'b1, "R9");
        @(negedge clk);
        cns_req = 1'b1; tmp_we = 1'b1; tmp_idx = 3'd5; tmp_wdata = 16'h2222;
        #1;
        check(cns_ready == 1'b1, "R9", cns_ready, 1);
        check(cns_data == 16'h1111, "R9", cns_data, 16'h1111);
        @(posedge clk);
        #1 begin cns_req = 1'b0; tmp_we = 1'b0; end
        next_cons++;
        produce(16, 1'b1, 5, 1'b1, "R9");
        consume(16'h2222, 1'b1, "R9");
        expect_stall("R5");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_inorder();
        t_reorder();
        t_assoc_full();
        t_latency();
        t_pointer();
        t_hazard();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule